// File: doc/BRIEF.md
# Four-Function Ripple Arithmetic Logic Unit

This block is a purely combinational arithmetic and logic unit for two N-bit operands. A 2-bit operation code chooses one of four functions: sum, difference, bitwise AND or bitwise OR. The chosen result appears on the output in the same cycle the operands are presented, with no register on any path.

Addition and subtraction share one carry chain made of explicitly instantiated one-bit full adder cells, each stage's carry-out feeding the carry-in of the stage above. For subtraction, every bit of the second operand passes through an XOR gate steered by the subtract control, which inverts it, and the chain's initial carry is set to one, so the chain forms the two's-complement difference. The unit reports the raw carry leaving the top stage and a signed-overflow flag formed from the carries entering and leaving the top stage. Both flags are held low for the two bitwise functions.

Top module: `ripple_alu`

## Requirements
- R1: With op_sel = 2'b00, result equals (opnd_a + opnd_b) modulo 2^WIDTH.
- R2: With op_sel = 2'b01, result equals (opnd_a - opnd_b) modulo 2^WIDTH.
- R3: With op_sel = 2'b10, result equals the bitwise AND of the two operands.
- R4: With op_sel = 2'b11, result equals the bitwise OR of the two operands.
- R5: With op_sel = 2'b00, carry_out is 1 exactly when the unsigned sum of the operands is at least 2^WIDTH.
- R6: With op_sel = 2'b01, carry_out is the carry leaving the top stage of opnd_a + ~opnd_b + 1, which is 1 exactly when opnd_a is unsigned greater than or equal to opnd_b.
- R7: With op_sel = 2'b00 or 2'b01, overflow is 1 exactly when the true signed (two's-complement) sum or difference lies outside the range -2^(WIDTH-1) to 2^(WIDTH-1)-1; this equals carry into the top stage differing from carry out of it.
- R8: With op_sel = 2'b10 or 2'b11, carry_out and overflow are both 0 for every operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand (subtrahend for subtraction) |
| op_sel | input | 2 | Function code: 00 add, 01 subtract, 10 AND, 11 OR |
| result | output | WIDTH | Selected function result |
| carry_out | output | 1 | Carry leaving the top adder stage, 0 for bitwise functions |
| overflow | output | 1 | Signed overflow flag, 0 for bitwise functions |

## Verification
The bench builds the unit with WIDTH set to 4, which shrinks the input space to 16 by 16 operand pairs per function. That makes a full sweep of all four codes affordable, so every carry pattern through the chain, both overflow directions, the most-negative operand and equal operands in subtraction are all reached rather than sampled. Expected results and flags come from integer arithmetic on signed and unsigned views of the operands.

// File: rtl/ripple_alu_pkg.sv
package ripple_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_OR  = 2'b11
  } alu_op_e;
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic half;
  assign half = a ^ b;
  assign s    = half ^ ci;
  assign co   = (a & b) | (half & ci);
endmodule

// File: rtl/rca_chain.sv
module rca_chain #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             cin_msb
);
  localparam int EXT = WIDTH + 1;

  logic [WIDTH:0] carry;
  assign carry[0] = sub;

  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_stage
      logic b_cond;
      assign b_cond = b[g] ^ sub;
      fa_cell u_fa (
        .a  (a[g]),
        .b  (b_cond),
        .ci (carry[g]),
        .s  (sum[g]),
        .co (carry[g+1])
      );
    end
  endgenerate

  assign cout    = carry[WIDTH];
  assign cin_msb = carry[WIDTH-1];

  always_comb begin
    assert_chain_sum_R1: assert ({cout, sum} ==
        EXT'({1'b0, a}) + EXT'({1'b0, (sub ? ~b : b)}) + EXT'(sub))
      else $error("carry chain disagrees with arithmetic sum");
  end
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
  import ripple_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [1:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow
);
  localparam int MSB = WIDTH - 1;

  alu_op_e op;
  assign op = alu_op_e'(op_sel);

  logic             do_sub;
  logic             is_arith;
  logic [WIDTH-1:0] chain_sum;
  logic             chain_cout;
  logic             chain_cmsb;

  assign do_sub   = (op == OP_SUB);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);

  rca_chain #(.WIDTH(WIDTH)) u_chain (
    .a       (opnd_a),
    .b       (opnd_b),
    .sub     (do_sub),
    .sum     (chain_sum),
    .cout    (chain_cout),
    .cin_msb (chain_cmsb)
  );

  always_comb begin
    unique case (op)
      OP_ADD,
      OP_SUB:  result = chain_sum;
      OP_AND:  result = opnd_a & opnd_b;
      OP_OR:   result = opnd_a | opnd_b;
      default: result = '0;
    endcase
  end

  assign carry_out = is_arith & chain_cout;
  assign overflow  = is_arith & (chain_cout ^ chain_cmsb);

  always_comb begin
    if (op == OP_SUB) begin
      assert_sub_diff_R2: assert (result == WIDTH'(opnd_a - opnd_b))
        else $error("difference wrong");
      assert_sub_carry_R6: assert (carry_out == (opnd_a >= opnd_b))
        else $error("subtract carry wrong");
    end
    if (op == OP_ADD && overflow) begin
      assert_ovf_add_R7: assert (opnd_a[MSB] == opnd_b[MSB] && result[MSB] != opnd_a[MSB])
        else $error("add overflow without sign pattern");
    end
    if (op == OP_SUB && overflow) begin
      assert_ovf_sub_R7: assert (opnd_a[MSB] != opnd_b[MSB] && result[MSB] != opnd_a[MSB])
        else $error("subtract overflow without sign pattern");
    end
    if (op_sel[1]) begin
      assert_logic_flags_R8: assert (!carry_out && !overflow)
        else $error("flags raised on bitwise function");
    end
  end
endmodule

// File: tb/ripple_alu_test.sv
module ripple_alu_test;
  localparam int W    = 4;
  localparam int SPAN = 1 << W;
  localparam int HALF = 1 << (W - 1);

  logic clk;
  logic rst_n;
  logic [W-1:0] opnd_a, opnd_b, result;
  logic [1:0]   op_sel;
  logic         carry_out, overflow;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ripple_alu #(.WIDTH(W)) uut (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_sel    (op_sel),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%0d b=%0d actual=%0d expected=%0d",
               req, op_sel, opnd_a, opnd_b, got, exp);
    end
  endtask

  function automatic int sview(input int v);
    return (v >= HALF) ? v - SPAN : v;
  endfunction

  initial begin
    rst_n  = 1'b0;
    opnd_a = '0;
    opnd_b = '0;
    op_sel = 2'b00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle result", int'(result), 0);
    check("R5 idle carry", int'(carry_out), 0);
    check("R7 idle overflow", int'(overflow), 0);

    for (int op = 0; op < 4; op++) begin
      for (int a = 0; a < SPAN; a++) begin
        for (int b = 0; b < SPAN; b++) begin
          @(posedge clk);
          op_sel = 2'(op);
          opnd_a = W'(a);
          opnd_b = W'(b);
          @(negedge clk);
          case (op)
            0: begin
              check("R1 sum", int'(result), (a + b) % SPAN);
              check("R5 add carry", int'(carry_out), (a + b >= SPAN) ? 1 : 0);
              check("R7 add overflow", int'(overflow),
                    ((sview(a) + sview(b) >= HALF) || (sview(a) + sview(b) < -HALF)) ? 1 : 0);
            end
            1: begin
              check("R2 difference", int'(result), (a - b + SPAN) % SPAN);
              check("R6 sub carry", int'(carry_out), (a >= b) ? 1 : 0);
              check("R7 sub overflow", int'(overflow),
                    ((sview(a) - sview(b) >= HALF) || (sview(a) - sview(b) < -HALF)) ? 1 : 0);
            end
            2: begin
              check("R3 and", int'(result), a & b);
              check("R8 and carry", int'(carry_out), 0);
              check("R8 and overflow", int'(overflow), 0);
            end
            default: begin
              check("R4 or", int'(result), a | b);
              check("R8 or carry", int'(carry_out), 0);
              check("R8 or overflow", int'(overflow), 0);
            end
          endcase
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog actual=timeout expected=completion");
        end
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule